// File: doc/BRIEF.md
# Indirect Register Access Bridge

A management host reaches the device through a small parallel register port. The port carries a bus address, a 5-bit register number, write data, and separate read and write strobes. Behind the bridge sits an internal register bus that uses a request/acknowledge handshake. That bus carries a device address, a register number and 16 bits of data. A strap input selects how host accesses reach the internal bus.

When the strap is zero, the bridge forwards each host access unchanged. The host bus address becomes the internal device address. The access completes when the internal bus acknowledges it.

When the strap is nonzero, the device occupies only the single host address equal to the strap. Two registers tunnel the accesses. The command register, at register number 0, holds the opcode, the target device and the target register, plus a self-clearing busy flag in its top bit. The data register, at register number 1, holds the data. To write, the host loads the data register, issues a write command, and polls the busy flag. To read, the host issues a read command, polls the busy flag, and then fetches the result from the data register.

Top module: `ind_reg_bridge`

## Requirements
- R1: With `strap_addr` equal to 0, each host strobe that arrives while no internal transfer is open starts an internal request on the next cycle. The request carries `int_dev` = `host_addr`, `int_reg` = `host_reg`, `int_we` = `host_wr` and `int_wdata` = `host_wdata`. `host_ack` pulses one cycle after the cycle in which `int_req` and `int_ack` are both high. For a read, `host_rdata` then holds the value of `int_rdata` from that acknowledge cycle.
- R2: With a nonzero strap, a strobe whose `host_addr` differs from `strap_addr` gets no `host_ack` and changes no register. A strobe at the strap address is answered by a `host_ack` pulse one cycle later. For a read, `host_rdata` is valid in the same cycle as that pulse.
- R3: The command word is laid out as follows. Bit 15 is start/busy. Bits 14:10 are the opcode, where 00110 means read (base 0x9800) and 00101 means write (base 0x9400). Bits 9:5 are the device and bits 4:0 are the register. A valid command written to register 0 while idle raises `int_req` on the next cycle, carrying those device and register fields.
- R4: Reading register 0 returns bit 15 as 1 from the cycle after a command is accepted until the cycle after the internal acknowledge. Bits 14:0 hold the last accepted command.
- R5: An internal write issued through a command carries the contents of the data register (register 1) on `int_wdata`.
- R6: When an internal read is acknowledged, `int_rdata` is stored in the data register. A host read of register 1 then returns it.
- R7: A command written while busy is ignored. It does not change the command fields, start a transfer, or alter the data register.
- R8: A command with bit 15 clear, or with an opcode other than 00110 or 00101, is ignored. It does not change the command fields or start a transfer.
- R9: `int_req`, `int_dev`, `int_reg`, `int_we` and `int_wdata` hold steady while `int_req` waits for `int_ack`. `int_req` drops on the cycle after the acknowledge.
- R10: After reset, `int_req` and `host_ack` are low, and registers 0 and 1 both read as 0.
- R11: In indirect mode, register numbers 2 to 31 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Strap: 0 selects pass-through, any other value is the device's own host address |
| host_addr | input | 5 | Host bus address of the access |
| host_reg | input | 5 | Host register number |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_rdata | output | 16 | Read data, valid with host_ack |
| host_ack | output | 1 | Access completion pulse |
| int_req | output | 1 | Internal bus request, held until acknowledged |
| int_we | output | 1 | Internal transfer is a write |
| int_dev | output | 5 | Internal device address |
| int_reg | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data, valid with int_ack |
| int_ack | input | 1 | Internal bus acknowledge |

## Verification
On every cycle, the assertions check the request handshake on the internal bus: the fields stay stable while a request waits, and the request drops after the acknowledge. They also check that foreign host addresses are never answered, that the own address is always answered, and the launch and completion timing of pass-through accesses. They further check that every internal request in indirect mode follows a command write with the start bit set. The bench scenarios cover everything that depends on data flow over whole command sequences. This includes the poll-until-idle protocol, the write data taken from the data register, read results landing in the data register, and commands dropped while busy or malformed, which is shown by the data and command fields that survive afterwards. A bench target with variable latency stretches the busy window.

// File: rtl/ind_reg_pkg.sv
package ind_reg_pkg;
   // Opcode field width of the command word
   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OPC_RD = 5'b00110,
      OPC_WR = 5'b00101
   } opc_e;

   // Register numbers inside the tunnel window
   localparam int CMD_REG_NUM  = 0;
   localparam int DATA_REG_NUM = 1;
endpackage

// File: rtl/ind_reg_cmd_decode.sv
module ind_reg_cmd_decode
   import ind_reg_pkg::*;
#(
   parameter int DEV_W  = 5,
   parameter int REG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] word,
   output logic              valid,
   output logic              is_wr,
   output logic [DEV_W-1:0]  dev,
   output logic [REG_W-1:0]  rg
);
   localparam int DEV_LSB = REG_W;
   localparam int OPC_LSB = REG_W + DEV_W;

   logic [OPC_W-1:0] opc;

   assign opc   = word[OPC_LSB +: OPC_W];
   assign dev   = word[DEV_LSB +: DEV_W];
   assign rg    = word[REG_W-1:0];
   assign is_wr = (opc == OPC_WR);
   assign valid = word[DATA_W-1] && ((opc == OPC_RD) || (opc == OPC_WR));
endmodule

// File: rtl/ind_reg_xfer.sv
module ind_reg_xfer #(
   parameter int DEV_W  = 5,
   parameter int REG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [DEV_W-1:0]  start_dev,
   input  logic [REG_W-1:0]  start_reg,
   input  logic [DATA_W-1:0] start_wdata,
   output logic              busy,
   output logic              done,
   output logic              int_req,
   output logic              int_we,
   output logic [DEV_W-1:0]  int_dev,
   output logic [REG_W-1:0]  int_reg,
   output logic [DATA_W-1:0] int_wdata,
   input  logic              int_ack
);
   logic              req_q;
   logic              we_q;
   logic [DEV_W-1:0]  dev_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         dev_q   <= '0;
         reg_q   <= '0;
         wdata_q <= '0;
      end else if (!req_q) begin
         if (start) begin
            req_q   <= 1'b1;
            we_q    <= start_we;
            dev_q   <= start_dev;
            reg_q   <= start_reg;
            wdata_q <= start_wdata;
         end
      end else if (int_ack) begin
         req_q <= 1'b0;
      end
   end

   assign busy      = req_q;
   assign done      = req_q & int_ack;
   assign int_req   = req_q;
   assign int_we    = we_q;
   assign int_dev   = dev_q;
   assign int_reg   = reg_q;
   assign int_wdata = wdata_q;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
   import ind_reg_pkg::*;
#(
   parameter int DEV_W     = 5,
   parameter int REG_W     = 5,
   parameter int DATA_W    = 16,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEV_W-1:0]  strap_addr,
   input  logic [DEV_W-1:0]  host_addr,
   input  logic [REG_W-1:0]  host_reg,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_ack,
   output logic              int_req,
   output logic              int_we,
   output logic [DEV_W-1:0]  int_dev,
   output logic [REG_W-1:0]  int_reg,
   output logic [DATA_W-1:0] int_wdata,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic              int_ack
);
   localparam int CMD_LOW_W = DATA_W - 1;

   if (DATA_W != 1 + OPC_W + DEV_W + REG_W) begin : g_bad_layout
      $error("command word must hold busy, opcode, device and register fields");
   end
   if (REG_W < 1 || DEV_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic                 direct_mode;
   logic                 strobe, sel;
   logic                 cmd_wr, data_wr;
   logic                 cmd_ok, dec_we;
   logic [DEV_W-1:0]     dec_dev;
   logic [REG_W-1:0]     dec_reg;
   logic                 busy, done;
   logic                 cmd_accept, dir_start, start;
   logic                 start_we;
   logic [DEV_W-1:0]     start_dev;
   logic [REG_W-1:0]     start_reg;
   logic [DATA_W-1:0]    start_wdata;
   logic [CMD_LOW_W-1:0] cmd_q;
   logic [DATA_W-1:0]    data_q;
   logic [DATA_W-1:0]    rd_mux;

   // Pass-through is a build option; without it the strap only names the address
   if (DIRECT_EN) begin : g_direct
      assign direct_mode = (strap_addr == '0);
   end else begin : g_indirect_only
      assign direct_mode = 1'b0;
   end

   assign strobe  = host_wr | host_rd;
   assign sel     = !direct_mode && strobe && (host_addr == strap_addr);
   assign cmd_wr  = sel && host_wr && (host_reg == REG_W'(CMD_REG_NUM));
   assign data_wr = sel && host_wr && (host_reg == REG_W'(DATA_REG_NUM));

   ind_reg_cmd_decode #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_dec (
      .word  (host_wdata),
      .valid (cmd_ok),
      .is_wr (dec_we),
      .dev   (dec_dev),
      .rg    (dec_reg)
   );

   assign cmd_accept  = cmd_wr && cmd_ok && !busy;
   assign dir_start   = direct_mode && strobe && !busy;
   assign start       = cmd_accept | dir_start;
   assign start_we    = direct_mode ? host_wr    : dec_we;
   assign start_dev   = direct_mode ? host_addr  : dec_dev;
   assign start_reg   = direct_mode ? host_reg   : dec_reg;
   assign start_wdata = direct_mode ? host_wdata : data_q;

   ind_reg_xfer #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_we    (start_we),
      .start_dev   (start_dev),
      .start_reg   (start_reg),
      .start_wdata (start_wdata),
      .busy        (busy),
      .done        (done),
      .int_req     (int_req),
      .int_we      (int_we),
      .int_dev     (int_dev),
      .int_reg     (int_reg),
      .int_wdata   (int_wdata),
      .int_ack     (int_ack)
   );

   always_comb begin
      if (host_reg == REG_W'(CMD_REG_NUM))       rd_mux = {busy, cmd_q};
      else if (host_reg == REG_W'(DATA_REG_NUM)) rd_mux = data_q;
      else                                       rd_mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         data_q     <= '0;
         host_ack   <= 1'b0;
         host_rdata <= '0;
      end else begin
         if (cmd_accept) cmd_q <= host_wdata[CMD_LOW_W-1:0];
         // A completed internal read takes precedence over a host data write
         if (done && !int_we && !direct_mode) data_q <= int_rdata;
         else if (data_wr)                     data_q <= host_wdata;
         if (direct_mode) begin
            host_ack <= done;
            if (done) host_rdata <= int_we ? '0 : int_rdata;
         end else begin
            host_ack <= sel;
            if (sel && host_rd) host_rdata <= rd_mux;
         end
      end
   end
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
   parameter int DEV_W     = 5,
   parameter int REG_W     = 5,
   parameter int DATA_W    = 16,
   parameter bit DIRECT_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DEV_W-1:0]  strap_addr,
   input logic [DEV_W-1:0]  host_addr,
   input logic [REG_W-1:0]  host_reg,
   input logic [DATA_W-1:0] host_wdata,
   input logic              host_wr,
   input logic              host_rd,
   input logic              host_ack,
   input logic              int_req,
   input logic              int_we,
   input logic [DEV_W-1:0]  int_dev,
   input logic [REG_W-1:0]  int_reg,
   input logic [DATA_W-1:0] int_wdata,
   input logic              int_ack
);
   logic strobe, dir_mode, own_hit;
   assign strobe   = host_wr | host_rd;
   assign dir_mode = DIRECT_EN && (strap_addr == '0);
   assign own_hit  = !dir_mode && (host_addr == strap_addr);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req && !int_ack |=> int_req && $stable(int_dev) && $stable(int_reg)
                              && $stable(int_we) && $stable(int_wdata));
   // R9
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req && int_ack |=> !int_req);
   // R2
   foreign_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_mode && strobe && !own_hit |=> !host_ack);
   // R2
   own_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && own_hit |=> host_ack);
   // R1
   direct_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_mode && strobe && !int_req |=> int_req && int_dev == $past(host_addr)
                                         && int_reg == $past(host_reg));
   // R1
   direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_mode && int_req && int_ack |=> host_ack);
   // R3
   cmd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_mode && $rose(int_req) |-> $past(host_wr && own_hit && host_reg == '0
                                           && host_wdata[DATA_W-1]));
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(
   .DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W), .DIRECT_EN(DIRECT_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .host_addr(host_addr),
   .host_reg(host_reg), .host_wdata(host_wdata), .host_wr(host_wr),
   .host_rd(host_rd), .host_ack(host_ack), .int_req(int_req), .int_we(int_we),
   .int_dev(int_dev), .int_reg(int_reg), .int_wdata(int_wdata), .int_ack(int_ack)
);

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  strap_addr = '0;
   logic [4:0]  host_addr = '0;
   logic [4:0]  host_reg = '0;
   logic [15:0] host_wdata = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [15:0] host_rdata;
   logic        host_ack;
   logic        int_req, int_we;
   logic [4:0]  int_dev, int_reg;
   logic [15:0] int_wdata;
   logic [15:0] int_rdata = '0;
   logic        int_ack = 1'b0;

   int n_cmp = 0, n_bad = 0;
   int force_lat = -1;
   int lat_cnt = 0, lat_tgt = 1;
   logic [15:0] tmem [0:1023];
   logic [15:0] expm [0:1023];
   logic [4:0]  S;

   always #2 clk = ~clk;

   ind_reg_bridge u_ind_reg_bridge (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .host_addr(host_addr),
      .host_reg(host_reg), .host_wdata(host_wdata), .host_wr(host_wr),
      .host_rd(host_rd), .host_rdata(host_rdata), .host_ack(host_ack),
      .int_req(int_req), .int_we(int_we), .int_dev(int_dev), .int_reg(int_reg),
      .int_wdata(int_wdata), .int_rdata(int_rdata), .int_ack(int_ack)
   );

   function automatic logic [15:0] seed_val(input int i);
      return 16'((i * 40503 + 12345) ^ (i << 7));
   endfunction
   function automatic logic [15:0] cmd_word(input bit wr, input logic [4:0] d,
                                            input logic [4:0] r);
      return (wr ? 16'h9400 : 16'h9800) | {6'b0, d, r};
   endfunction

   // Internal target with variable latency, driven away from the active edge
   always @(negedge clk) begin
      if (int_ack) begin
         int_ack = 1'b0;
      end else if (int_req) begin
         if (lat_cnt >= lat_tgt) begin
            if (int_we) tmem[{int_dev, int_reg}] = int_wdata;
            else        int_rdata = tmem[{int_dev, int_reg}];
            int_ack = 1'b1;
            lat_cnt = 0;
            lat_tgt = (force_lat >= 0) ? force_lat : int'($urandom % 4);
         end else begin
            lat_cnt++;
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic hacc(input logic [4:0] a, input logic [4:0] r, input bit wr,
                       input logic [15:0] d, input bit want_ack,
                       output logic [15:0] q, output bit acked);
      @(negedge clk);
      host_addr = a; host_reg = r; host_wdata = d; host_wr = wr; host_rd = !wr;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      acked = 1'b0; q = 'x;
      for (int i = 0; i < 80; i++) begin
         if (host_ack) begin acked = 1'b1; q = host_rdata; break; end
         if (!want_ack && i == 3) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_idle(output logic [15:0] last);
      logic [15:0] q; bit a;
      last = 16'hffff;
      for (int i = 0; i < 60; i++) begin
         hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
         last = q;
         if (!q[15]) break;
      end
   endtask

   task automatic ind_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
      logic [15:0] q; bit a;
      hacc(S, 5'd1, 1'b1, v, 1'b1, q, a);
      hacc(S, 5'd0, 1'b1, cmd_word(1'b1, d, r), 1'b1, q, a);
      wait_idle(q);
      expm[{d, r}] = v;
   endtask

   task automatic ind_read(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v);
      logic [15:0] q; bit a;
      hacc(S, 5'd0, 1'b1, cmd_word(1'b0, d, r), 1'b1, q, a);
      wait_idle(q);
      hacc(S, 5'd1, 1'b0, 16'h0, 1'b1, v, a);
   endtask

   task automatic do_reset(input logic [4:0] s);
      @(negedge clk);
      rst_n = 1'b0; strap_addr = s; S = s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] q, q2, v;
      bit a;
      void'($urandom(32'd1234));
      for (int i = 0; i < 1024; i++) begin
         tmem[i] = seed_val(i);
         expm[i] = seed_val(i);
      end

      // Reset state, indirect strap 5
      do_reset(5'd5);
      chk("R10 int_req after reset", {15'b0, int_req}, 16'h0);
      chk("R10 host_ack after reset", {15'b0, host_ack}, 16'h0);
      hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
      chk("R10 command reg after reset", q, 16'h0);
      hacc(S, 5'd1, 1'b0, 16'h0, 1'b1, q, a);
      chk("R10 data reg after reset", q, 16'h0);

      // Directed write then read back through the tunnel
      ind_write(5'd3, 5'd9, 16'hA5C3);
      chk("R5 target got data-register value", tmem[{5'd3, 5'd9}], 16'hA5C3);
      hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
      chk("R4 command fields after write", q, cmd_word(1'b1, 5'd3, 5'd9) & 16'h7fff);
      ind_read(5'd17, 5'd2, q);
      chk("R6 read result in data reg", q, expm[{5'd17, 5'd2}]);
      hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
      chk("R3 read command fields kept", q, cmd_word(1'b0, 5'd17, 5'd2) & 16'h7fff);

      // Random tunnel traffic with random target latency
      for (int k = 0; k < 20; k++) begin
         logic [4:0] d, r; logic [15:0] val;
         d = 5'($urandom); r = 5'($urandom); val = 16'($urandom);
         ind_write(d, r, val);
         ind_read(d, r, q);
         chk("R5 R6 random tunnel round trip", q, expm[{d, r}]);
         d = 5'($urandom); r = 5'($urandom);
         ind_read(d, r, q);
         chk("R6 random tunnel read", q, expm[{d, r}]);
      end

      // Busy window with long latency, and a command while busy
      force_lat = 20; lat_tgt = 20;
      hacc(S, 5'd1, 1'b1, 16'h1357, 1'b1, q, a);
      hacc(S, 5'd0, 1'b1, cmd_word(1'b1, 5'd4, 5'd4), 1'b1, q, a);
      chk("R3 request raised by valid command", {15'b0, int_req}, 16'h1);
      chk("R3 request device field", {11'b0, int_dev}, 16'd4);
      hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
      chk("R4 busy bit set while pending", q, cmd_word(1'b1, 5'd4, 5'd4));
      hacc(S, 5'd0, 1'b1, cmd_word(1'b0, 5'd8, 5'd8), 1'b1, q, a);
      wait_idle(q);
      expm[{5'd4, 5'd4}] = 16'h1357;
      chk("R4 busy clears, fields of first command", q, cmd_word(1'b1, 5'd4, 5'd4) & 16'h7fff);
      chk("R7 write completed", tmem[{5'd4, 5'd4}], 16'h1357);
      repeat (3) @(negedge clk);
      chk("R7 no second transfer", {15'b0, int_req}, 16'h0);
      hacc(S, 5'd1, 1'b0, 16'h0, 1'b1, q, a);
      chk("R7 data reg not overwritten", q, 16'h1357);
      force_lat = -1;

      // Malformed commands
      hacc(S, 5'd0, 1'b1, 16'h1800 | 16'h0021, 1'b1, q, a);
      chk("R8 start bit clear: no request", {15'b0, int_req}, 16'h0);
      hacc(S, 5'd0, 1'b1, 16'h9C00 | 16'h0042, 1'b1, q, a);
      chk("R8 bad opcode: no request", {15'b0, int_req}, 16'h0);
      hacc(S, 5'd0, 1'b0, 16'h0, 1'b1, q, a);
      chk("R8 command fields unchanged", q, cmd_word(1'b1, 5'd4, 5'd4) & 16'h7fff);

      // Unused register numbers
      hacc(S, 5'd7, 1'b1, 16'hDEAD, 1'b1, q, a);
      hacc(S, 5'd7, 1'b0, 16'h0, 1'b1, q, a);
      chk("R11 reg 7 reads zero", q, 16'h0);
      hacc(S, 5'd1, 1'b0, 16'h0, 1'b1, q, a);
      chk("R11 data reg unaffected", q, 16'h1357);

      // Foreign host address
      hacc(5'd6, 5'd1, 1'b1, 16'hBEEF, 1'b0, q, a);
      chk("R2 foreign write not acked", {15'b0, a}, 16'h0);
      hacc(5'd6, 5'd0, 1'b1, cmd_word(1'b1, 5'd1, 5'd1), 1'b0, q, a);
      chk("R2 foreign command no request", {15'b0, int_req}, 16'h0);
      hacc(S, 5'd1, 1'b0, 16'h0, 1'b1, q, a);
      chk("R2 data reg unchanged", q, 16'h1357);
      chk("R2 own address acked", {15'b0, a}, 16'h1);

      // Pass-through mode
      do_reset(5'd0);
      for (int k = 0; k < 30; k++) begin
         logic [4:0] d, r; logic [15:0] val;
         d = 5'($urandom); r = 5'($urandom); val = 16'($urandom);
         hacc(d, r, 1'b1, val, 1'b1, q, a);
         expm[{d, r}] = val;
         chk("R1 direct write acked", {15'b0, a}, 16'h1);
         chk("R1 direct write reached target", tmem[{d, r}], val);
         hacc(d, r, 1'b0, 16'h0, 1'b1, q2, a);
         chk("R1 direct read back", q2, val);
         d = 5'($urandom); r = 5'($urandom);
         hacc(d, r, 1'b0, 16'h0, 1'b1, v, a);
         chk("R1 direct random read", v, expm[{d, r}]);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule